// File: doc/BRIEF.md
# Automatic Measurement Range Controller

This block sequences the conversions of an integrating light-to-digital converter and chooses the full-scale range code used for each one. A configuration write sets a 4-bit range field, a conversion-time bit, a 2-bit mode field and an exponent-mask bit, and it strobes `cfg_wr`. That strobe cancels any conversion in progress and, unless the mode is shutdown, starts a new sequence. The controller opens an integration window on the converter interface. The window is a start pulse, a range code and a level that stays high for the window length, which is timed in clock cycles. The controller then waits for the converter's done pulse, which carries a 12-bit mantissa and an overflow bit.

In automatic mode the controller first takes a short assessment measurement at the top range. It uses that reading to choose the range of the full-length measurement. Between full measurements it lowers the range by one or two codes, or raises it by one code, depending on where the mantissa falls. An overflow below the top range is never reported: the controller reassesses and then measures again. Each valid result is published as a 16-bit word with a 4-bit exponent and a 12-bit mantissa, together with an overflow flag and a one-cycle completion pulse. In single-shot mode an extra pulse asks the configuration register to return its mode field to shutdown.

Top module: `lux_range_ctrl`

## Requirements
- R1: A range field of 12 selects automatic ranging. Codes 0 to 11 fix the range at that code, and the reserved codes 13 to 15 fix it at 11.
- R2: An automatic sequence begins with an assessment window at range 11. The following full measurement uses the smallest range r for which the assessment mantissa times 2^(11-r) is below 3584. An overflowing assessment selects range 11.
- R3: After an automatic full result with mantissa m, the next range is set by m. If m < 1024 the range drops by two codes. If 1024 <= m < 2048 it drops by one. If m > 3584 it rises by one. Otherwise it is unchanged. The range never goes below 0 or above 11.
- R4: An automatic full measurement that overflows below range 11 produces no completion pulse. It is followed by one assessment window and then a full measurement at the newly chosen range.
- R5: In automatic mode `res_ovf` is 1 only for a result that overflowed at range 11, and every other result clears it. In fixed mode it copies the converter's overflow bit for each result.
- R6: `cnv_integ` stays high for 10*TICKS_PER_MS cycles for an assessment window. A full window lasts 100*TICKS_PER_MS cycles when `cfg_long` is 0 and 800*TICKS_PER_MS cycles when it is 1.
- R7: Mode 1 (single-shot) gives exactly one result; `oneshot_clr` pulses with its `res_valid` and no further window starts. Modes 2 and 3 start the next full window in the same cycle as each result, at the stepped range.
- R8: `cfg_wr` during a window or while waiting for done pulses `cnv_abort` for one cycle and discards the pending result. It then starts a new sequence if `cfg_mode` is nonzero, and stays idle if `cfg_mode` is 0.
- R9: `res_word[15:12]` holds the exponent and `res_word[11:0]` holds the mantissa. In fixed mode with `cfg_mask_exp` = 1 the exponent reads 0. In automatic mode the exponent is the range used, whatever the mask bit.
- R10: After reset all outputs are 0, and no window starts until `cfg_wr` arrives with a nonzero mode.
- R11: `cnv_start` is a one-cycle pulse in the first cycle of each window, and `cnv_range` holds steady for the rest of that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_range | input | 4 | Range field (12 = automatic) |
| cfg_long | input | 1 | Conversion-time select (0 = 100 ms, 1 = 800 ms) |
| cfg_mode | input | 2 | 0 shutdown, 1 single-shot, 2/3 continuous |
| cfg_mask_exp | input | 1 | Zero the reported exponent in fixed mode |
| cfg_wr | input | 1 | Configuration write strobe (abort/start) |
| cnv_done | input | 1 | Converter result-ready pulse |
| cnv_mant | input | 12 | Converter mantissa |
| cnv_ovf | input | 1 | Converter overflow |
| cnv_start | output | 1 | First cycle of an integration window |
| cnv_integ | output | 1 | High while integrating |
| cnv_abort | output | 1 | Cancel pulse for the running conversion |
| cnv_range | output | 4 | Range code for the current window |
| res_word | output | 16 | Exponent and mantissa of the last result |
| res_ovf | output | 1 | Overflow flag of the last result |
| res_valid | output | 1 | One-cycle result completion pulse |
| oneshot_clr | output | 1 | Request to return the mode field to shutdown |

## Verification
The main function is driven with fixed light levels across fixed, masked, reserved and automatic range settings. Each level is chosen so that the reported exponent tells the assessment choice apart from a fixed range. A continuous run then moves the light level step by step, so that the results show a two-code drop, a one-code drop, a one-code rise, an unreported overflow retry, and an overflow at the top range that is reported with no retry. Directed cases measure the window lengths and check aborts with a restart and with shutdown.

// File: rtl/lrc_pkg.sv
`timescale 1ns/1ps
package lrc_pkg;
  localparam int MANT_W  = 12;
  localparam int EXP_W   = 4;
  localparam int RNG_TOP = 11;
  localparam int SCL_W   = MANT_W + RNG_TOP + 1;
  localparam int FULL    = 1 << MANT_W;

  localparam logic [EXP_W-1:0]  RNG_MAX   = EXP_W'(RNG_TOP);
  localparam logic [EXP_W-1:0]  RNG_AUTO  = EXP_W'(RNG_TOP + 1);
  localparam logic [MANT_W-1:0] QTR_MARK  = MANT_W'(FULL / 4);
  localparam logic [MANT_W-1:0] HALF_MARK = MANT_W'(FULL / 2);
  localparam logic [MANT_W-1:0] HI_MARK   = MANT_W'(FULL * 7 / 8);

  typedef enum logic [1:0] {S_IDLE, S_INTEG, S_WAIT} seq_state_t;

  // Smallest range whose extrapolated mantissa stays under the up-step mark.
  function automatic logic [EXP_W-1:0] pick_range(input logic [MANT_W-1:0] m);
    logic [EXP_W-1:0] r;
    logic [SCL_W-1:0] scaled;
    r = RNG_MAX;
    for (int k = RNG_TOP - 1; k >= 0; k--) begin
      scaled = {{(RNG_TOP + 1){1'b0}}, m} << (RNG_TOP - k);
      if (scaled < SCL_W'(HI_MARK)) r = EXP_W'(k);
    end
    return r;
  endfunction

  // Range for the next full measurement after a good one.
  function automatic logic [EXP_W-1:0] step_range(input logic [EXP_W-1:0] r,
                                                  input logic [MANT_W-1:0] m);
    if (m < QTR_MARK)       return (r > EXP_W'(1)) ? r - EXP_W'(2) : '0;
    else if (m < HALF_MARK) return (r != '0) ? r - EXP_W'(1) : '0;
    else if (m > HI_MARK)   return (r < RNG_MAX) ? r + EXP_W'(1) : RNG_MAX;
    else                    return r;
  endfunction
endpackage

// File: rtl/lrc_timer.sv
`timescale 1ns/1ps
module lrc_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clear,
  input  logic [CW-1:0] len,
  output logic          expire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= len;
    else if (clear)        cnt <= '0;
    else if (cnt != '0)    cnt <= cnt - CW'(1);
  end

  assign expire = (cnt == CW'(1)) && !load;
endmodule

// File: rtl/lrc_decide.sv
`timescale 1ns/1ps
module lrc_decide import lrc_pkg::*; (
  input  logic                    assess_ph,
  input  logic                    auto_run,
  input  logic                    mask_exp,
  input  logic [EXP_W-1:0]        rng,
  input  logic [MANT_W-1:0]       mant,
  input  logic                    ovf,
  output logic                    go_full,
  output logic                    go_retry,
  output logic                    go_report,
  output logic [EXP_W-1:0]        nxt_rng,
  output logic [EXP_W+MANT_W-1:0] rpt_word,
  output logic                    rpt_ovf
);
  logic [EXP_W-1:0] shown_exp;

  always_comb begin
    go_full   = 1'b0;
    go_retry  = 1'b0;
    go_report = 1'b0;
    nxt_rng   = rng;
    rpt_ovf   = 1'b0;
    shown_exp = (!auto_run && mask_exp) ? '0 : rng;
    rpt_word  = {shown_exp, mant};
    if (assess_ph) begin
      go_full = 1'b1;
      nxt_rng = ovf ? RNG_MAX : pick_range(mant);
    end else if (auto_run && ovf && (rng != RNG_MAX)) begin
      go_retry = 1'b1;
      nxt_rng  = RNG_MAX;
    end else begin
      go_report = 1'b1;
      rpt_ovf   = auto_run ? (ovf && (rng == RNG_MAX)) : ovf;
      nxt_rng   = auto_run ? step_range(rng, mant) : rng;
    end
  end
endmodule

// File: rtl/lrc_result.sv
`timescale 1ns/1ps
module lrc_result import lrc_pkg::*; (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    report,
  input  logic [EXP_W+MANT_W-1:0] word_in,
  input  logic                    ovf_in,
  output logic [EXP_W+MANT_W-1:0] res_word,
  output logic                    res_ovf,
  output logic                    res_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_word  <= '0;
      res_ovf   <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= report;
      if (report) begin
        res_word <= word_in;
        res_ovf  <= ovf_in;
      end
    end
  end
endmodule

// File: rtl/lux_range_ctrl.sv
`timescale 1ns/1ps
module lux_range_ctrl import lrc_pkg::*; #(
  parameter int TICKS_PER_MS = 1000,
  parameter int ASSESS_MS    = 10,
  parameter int SHORT_MS     = 100,
  parameter int LONG_MS      = 800
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [EXP_W-1:0]        cfg_range,
  input  logic                    cfg_long,
  input  logic [1:0]              cfg_mode,
  input  logic                    cfg_mask_exp,
  input  logic                    cfg_wr,
  input  logic                    cnv_done,
  input  logic [MANT_W-1:0]       cnv_mant,
  input  logic                    cnv_ovf,
  output logic                    cnv_start,
  output logic                    cnv_integ,
  output logic                    cnv_abort,
  output logic [EXP_W-1:0]        cnv_range,
  output logic [EXP_W+MANT_W-1:0] res_word,
  output logic                    res_ovf,
  output logic                    res_valid,
  output logic                    oneshot_clr
);
  localparam int CW = $clog2(LONG_MS * TICKS_PER_MS + 1);
  localparam logic [CW-1:0] LEN_ASSESS = CW'(ASSESS_MS * TICKS_PER_MS);
  localparam logic [CW-1:0] LEN_SHORT  = CW'(SHORT_MS * TICKS_PER_MS);
  localparam logic [CW-1:0] LEN_LONG   = CW'(LONG_MS * TICKS_PER_MS);

  seq_state_t       state;
  logic [EXP_W-1:0] rng_q;
  logic             assess_q, auto_q;

  // Configuration decode
  logic             cfg_auto, run_cont;
  logic [EXP_W-1:0] fixed_rng;
  assign cfg_auto  = (cfg_range == RNG_AUTO);
  assign fixed_rng = (cfg_range > RNG_MAX) ? RNG_MAX : cfg_range;
  assign run_cont  = cfg_mode[1];

  // Decision on the returned sample
  logic                    dec_full, dec_retry, dec_report, dec_ovf;
  logic [EXP_W-1:0]        dec_rng;
  logic [EXP_W+MANT_W-1:0] dec_word;

  lrc_decide u_decide (
    .assess_ph (assess_q),
    .auto_run  (auto_q),
    .mask_exp  (cfg_mask_exp),
    .rng       (rng_q),
    .mant      (cnv_mant),
    .ovf       (cnv_ovf),
    .go_full   (dec_full),
    .go_retry  (dec_retry),
    .go_report (dec_report),
    .nxt_rng   (dec_rng),
    .rpt_word  (dec_word),
    .rpt_ovf   (dec_ovf)
  );

  // Named events for the checks
  logic sample_evt, retry_evt, report_evt;
  assign sample_evt = (state == S_WAIT) && cnv_done && !cfg_wr;
  assign retry_evt  = sample_evt && dec_retry;
  assign report_evt = sample_evt && dec_report;

  logic             launch, l_assess, go_idle, abort_now;
  logic [EXP_W-1:0] l_rng;
  logic [CW-1:0]    l_len;

  always_comb begin
    launch    = 1'b0;
    l_assess  = 1'b0;
    l_rng     = rng_q;
    go_idle   = 1'b0;
    abort_now = 1'b0;
    if (cfg_wr) begin
      abort_now = (state != S_IDLE);
      if (cfg_mode != 2'd0) begin
        launch   = 1'b1;
        l_assess = cfg_auto;
        l_rng    = cfg_auto ? RNG_MAX : fixed_rng;
      end else begin
        go_idle = 1'b1;
      end
    end else if (sample_evt) begin
      if (dec_full) begin
        launch = 1'b1;
        l_rng  = dec_rng;
      end else if (dec_retry) begin
        launch   = 1'b1;
        l_assess = 1'b1;
        l_rng    = RNG_MAX;
      end else if (run_cont) begin
        launch = 1'b1;
        l_rng  = auto_q ? dec_rng : fixed_rng;
      end else begin
        go_idle = 1'b1;
      end
    end
    l_len = l_assess ? LEN_ASSESS : (cfg_long ? LEN_LONG : LEN_SHORT);
  end

  logic tmr_expire;

  lrc_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (launch),
    .clear  (go_idle),
    .len    (l_len),
    .expire (tmr_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      rng_q       <= '0;
      assess_q    <= 1'b0;
      auto_q      <= 1'b0;
      cnv_start   <= 1'b0;
      cnv_abort   <= 1'b0;
      oneshot_clr <= 1'b0;
    end else begin
      cnv_start   <= launch;
      cnv_abort   <= abort_now;
      oneshot_clr <= report_evt && !run_cont;
      if (cfg_wr && launch) auto_q <= cfg_auto;
      if (launch) begin
        state    <= S_INTEG;
        rng_q    <= l_rng;
        assess_q <= l_assess;
      end else if (go_idle) begin
        state <= S_IDLE;
      end else if ((state == S_INTEG) && tmr_expire) begin
        state <= S_WAIT;
      end
    end
  end

  assign cnv_integ = (state == S_INTEG);
  assign cnv_range = rng_q;

  lrc_result u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .report    (report_evt),
    .word_in   (dec_word),
    .ovf_in    (dec_ovf),
    .res_word  (res_word),
    .res_ovf   (res_ovf),
    .res_valid (res_valid)
  );

  // Assertions
  a_r11_start_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> cnv_integ);
  a_r11_range_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_integ && !cnv_start) |-> $stable(cnv_range));
  a_r8_abort_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_abort |-> $past(state != S_IDLE));
  a_r4_retry_silent: assert property (@(posedge clk) disable iff (!rst_n)
    retry_evt |=> (!res_valid && cnv_start));
  a_r7_clr_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    oneshot_clr |-> (res_valid && !cnv_integ));
  a_r5_auto_ovf_top: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ovf && auto_q) |-> (res_word[EXP_W+MANT_W-1:MANT_W] == RNG_MAX));
  a_r1_range_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_integ |-> (cnv_range <= RNG_MAX));
endmodule

// File: tb/lux_range_ctrl_test.sv
`timescale 1ns/1ps
module lux_range_ctrl_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [3:0]  cfg_range = 4'd0;
  logic        cfg_long = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic        cfg_mask_exp = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cnv_done = 1'b0;
  logic [11:0] cnv_mant = '0;
  logic        cnv_ovf = 1'b0;
  logic        cnv_start, cnv_integ, cnv_abort, res_ovf, res_valid, oneshot_clr;
  logic [3:0]  cnv_range;
  logic [15:0] res_word;

  lux_range_ctrl #(.TICKS_PER_MS(2)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_range(cfg_range), .cfg_long(cfg_long),
    .cfg_mode(cfg_mode), .cfg_mask_exp(cfg_mask_exp), .cfg_wr(cfg_wr),
    .cnv_done(cnv_done), .cnv_mant(cnv_mant), .cnv_ovf(cnv_ovf),
    .cnv_start(cnv_start), .cnv_integ(cnv_integ), .cnv_abort(cnv_abort),
    .cnv_range(cnv_range), .res_word(res_word), .res_ovf(res_ovf),
    .res_valid(res_valid), .oneshot_clr(oneshot_clr));

  // Converter stub and result monitor
  int unsigned light = 0;
  logic [3:0]  cap_rng = '0, assess_rng = '0;
  logic        prev_integ = 1'b0;
  int integ_len = 0, last_len = 0, starts = 0, aborts = 0, assess_wins = 0;
  int valid_cnt = 0, clr_cnt = 0;
  logic [15:0] got_word = '0;
  logic        got_ovf = 1'b0;

  always @(negedge clk) begin
    cnv_done = 1'b0;
    if (cnv_start) begin cap_rng = cnv_range; starts++; integ_len = 0; end
    if (cnv_integ) integ_len++;
    if (cnv_abort) aborts++;
    if (prev_integ && !cnv_integ && !cnv_abort) begin
      int unsigned v;
      last_len = integ_len;
      if (integ_len == 20) begin assess_wins++; assess_rng = cap_rng; end
      v = light >> cap_rng;
      if (v > 4095) begin cnv_mant = 12'hFFF; cnv_ovf = 1'b1; end
      else begin cnv_mant = v[11:0]; cnv_ovf = 1'b0; end
      cnv_done = 1'b1;
    end
    prev_integ = cnv_integ;
    if (res_valid) begin valid_cnt++; got_word = res_word; got_ovf = res_ovf; end
    if (oneshot_clr) clr_cnt++;
  end

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] r, input logic lg, input logic [1:0] md,
                           input logic mk);
    @(negedge clk);
    cfg_range = r; cfg_long = lg; cfg_mode = md; cfg_mask_exp = mk; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_result(input string tag);
    int n0 = valid_cnt;
    int t = 0;
    while (valid_cnt == n0 && t < 5000) begin @(negedge clk); #1; t++; end
    if (valid_cnt == n0) begin
      checks++; errors++;
      $display("FAIL %s actual=timeout expected=result", tag);
    end
  endtask

  typedef struct packed {
    logic [3:0]  rng;
    logic        mask;
    logic [23:0] lux;
    logic [15:0] word;
    logic        ovf;
    logic        assess;
  } vec_t;

  localparam vec_t VEC [0:8] = '{
    '{4'd3,  1'b0, 24'd1000,     16'h307D, 1'b0, 1'b0},
    '{4'd3,  1'b1, 24'd1000,     16'h007D, 1'b0, 1'b0},
    '{4'd0,  1'b0, 24'd5000,     16'h0FFF, 1'b1, 1'b0},
    '{4'd12, 1'b0, 24'd5000,     16'h19C4, 1'b0, 1'b1},
    '{4'd12, 1'b0, 24'd300,      16'h012C, 1'b0, 1'b1},
    '{4'd12, 1'b1, 24'd5000,     16'h19C4, 1'b0, 1'b1},
    '{4'd12, 1'b0, 24'd10000000, 16'hBFFF, 1'b1, 1'b1},
    '{4'd13, 1'b0, 24'd1000000,  16'hB1E8, 1'b0, 1'b0},
    '{4'd12, 1'b0, 24'd3000000,  16'hAB71, 1'b0, 1'b1}
  };

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int a0, c0, s0, n0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(res_word == 16'h0 && !res_ovf && !res_valid, "R10 reset result", res_word, 0);
    check(!cnv_integ && !cnv_start && !oneshot_clr && !cnv_abort, "R10 reset converter",
          cnv_integ, 0);
    cfg_write(4'd3, 1'b0, 2'd0, 1'b0);
    repeat (20) @(negedge clk);
    check(starts == 0, "R10 mode0 write starts nothing", starts, 0);

    // Table of single-shot measurements (R1 R2 R5 R7 R9)
    for (int i = 0; i < 9; i++) begin
      light = VEC[i].lux;
      a0 = assess_wins; c0 = clr_cnt;
      cfg_write(VEC[i].rng, 1'b0, 2'd1, VEC[i].mask);
      wait_result($sformatf("R1 vector %0d", i));
      repeat (2) @(negedge clk);
      check(got_word == VEC[i].word, $sformatf("R1 R9 vector %0d word", i), got_word,
            VEC[i].word);
      check(got_ovf == VEC[i].ovf, $sformatf("R5 vector %0d ovf", i), got_ovf, VEC[i].ovf);
      check((assess_wins - a0) == int'(VEC[i].assess), $sformatf("R2 vector %0d assess", i),
            assess_wins - a0, VEC[i].assess);
      check((clr_cnt - c0) == 1, $sformatf("R7 vector %0d oneshot_clr", i), clr_cnt - c0, 1);
      if (i == 0) check(last_len == 200, "R6 short window", last_len, 200);
    end
    s0 = starts;
    repeat (300) @(negedge clk);
    check(starts == s0 && !cnv_integ, "R7 single-shot stays idle", starts, s0);
    check(assess_rng == 4'd11, "R2 assessment range", assess_rng, 11);

    // Continuous automatic run (R3 R4 R5 R7)
    light = 3000000;
    cfg_write(4'd12, 1'b0, 2'd2, 1'b0);
    wait_result("R7 cont 1");
    check(got_word == 16'hAB71, "R2 cont first", got_word, 16'hAB71);
    light = 600000;
    wait_result("R3 cont 2");
    check(got_word == 16'hA249, "R3 mid range held", got_word, 16'hA249);
    wait_result("R3 cont 3");
    check(got_word == 16'h8927, "R3 drop by two", got_word, 16'h8927);
    light = 1000000;
    wait_result("R3 cont 4");
    check(got_word == 16'h8F42, "R3 held before rise", got_word, 16'h8F42);
    wait_result("R3 cont 5");
    check(got_word == 16'h97A1, "R3 rise by one", got_word, 16'h97A1);
    light = 5000000;
    a0 = assess_wins; n0 = valid_cnt;
    wait_result("R4 cont 6");
    check(got_word == 16'hB989 && !got_ovf, "R4 retry result after drop by one",
          got_word, 16'hB989);
    check((assess_wins - a0) == 1 && (valid_cnt - n0) == 1, "R4 one silent reassessment",
          assess_wins - a0, 1);
    light = 10000000;
    a0 = assess_wins;
    wait_result("R5 cont 7");
    check(got_word == 16'hBFFF && got_ovf, "R5 top range overflow reported", got_word,
          16'hBFFF);
    check(assess_wins == a0, "R4 no retry at top range", assess_wins - a0, 0);
    light = 1000000;
    wait_result("R5 cont 8");
    check(got_word == 16'hB1E8 && !got_ovf, "R5 flag cleared", got_ovf, 0);

    // Abort with restart (R8)
    repeat (50) @(negedge clk);
    a0 = aborts; light = 1000;
    cfg_write(4'd2, 1'b0, 2'd1, 1'b0);
    wait_result("R8 restart");
    check(got_word == 16'h20FA, "R8 new config result", got_word, 16'h20FA);
    check((aborts - a0) == 1, "R8 abort pulse", aborts - a0, 1);

    // Abort into shutdown (R8)
    light = 5000;
    cfg_write(4'd12, 1'b0, 2'd3, 1'b0);
    repeat (30) @(negedge clk);
    a0 = aborts; n0 = valid_cnt;
    cfg_write(4'd12, 1'b0, 2'd0, 1'b0);
    s0 = starts;
    repeat (2000) @(negedge clk);
    check(valid_cnt == n0 && starts == s0 && !cnv_integ, "R8 shutdown stops",
          valid_cnt - n0, 0);
    check((aborts - a0) == 1, "R8 shutdown abort pulse", aborts - a0, 1);

    // Long window (R6)
    light = 1000;
    cfg_write(4'd5, 1'b1, 2'd1, 1'b0);
    wait_result("R6 long");
    check(got_word == 16'h501F, "R6 long result", got_word, 16'h501F);
    check(last_len == 1600, "R6 long window", last_len, 1600);

    finish_run();
  end
endmodule